// File: doc/BRIEF.md
# Processor Exception Entry Unit

This unit commits the state change that moves a processor core into an exception handler. The pipeline presents one request at a time. A request carries the faulting program counter, a cause code, an optional faulting virtual address and a flag that marks it as a debug request. From the current processor status the unit decides which handler vector applies. It saves the return PC into the right save register, records the cause, raises the exception-mode bit and pulses a redirect output together with the vector ID.

General exceptions pick a vector from the exception-mode and user-mode bits of the status word. A general exception that arrives while exception mode is already set goes to the double-exception vector and saves its PC into a separate double-exception PC register. Debug requests are taken only when the current interrupt level is below a configured debug level. A taken debug request uses a per-level pair of PC and status save registers and raises the interrupt level of the status word to the debug level. A small special-register port lets software read and write every held register.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset the status word, every save register, the cause registers and the address register read 0, `redirect` is 0 and `vector_id` is 0.
- R2: The status word is 6 bits wide: interrupt level in bits 3:0, exception mode (EXCM) in bit 4, user mode (UM) in bit 5. A general exception (`exc_valid`=1, `exc_debug`=0) with EXCM clear stores the PC into EPC1. It selects vector 1 (user) when UM is set and vector 0 (kernel) when UM is clear.
- R3: A general exception with EXCM already set selects vector 2 (double). It stores the PC into DEPC and leaves EPC1 unchanged.
- R4: Every general exception writes `exc_cause` into EXCCAUSE and sets EXCM. UM and the interrupt level stay unchanged.
- R5: A general exception with `exc_has_addr`=1 writes `exc_addr` into EXCVADDR. With `exc_has_addr`=0, EXCVADDR keeps its value.
- R6: The current level is the larger of the interrupt level and (EXCM ? EXC_LEVEL : 0). A debug request is taken only when the current level is strictly below DEBUG_LEVEL. Otherwise it is dropped: no register changes and no redirect occurs.
- R7: A taken debug request stores the PC into the level-DEBUG_LEVEL PC save register and the old status word into the level-DEBUG_LEVEL status save register. It writes the cause into DEBUGCAUSE, sets the interrupt level to DEBUG_LEVEL, sets EXCM, keeps UM, leaves EXCCAUSE unchanged and selects vector 3 (debug).
- R8: `redirect` is high for exactly the one cycle after the clock edge that takes a request. `vector_id` is loaded on that same edge and holds until the next taken request.
- R9: The special-register map is: 0 status word (writes keep bits 5:0), 1 EPC1, 2 DEPC, 3 EXCCAUSE, 4 EXCVADDR, 5 DEBUGCAUSE, 8+L PC save for level L, 16+L status save for level L (L from 2 to MAX_LEVEL). Reads are combinational, and unmapped addresses read 0.
- R10: A special-register write in the same cycle as a taken request is discarded. A write in the same cycle as a dropped debug request takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception request present this cycle |
| exc_debug | input | 1 | Request is a debug request |
| exc_pc | input | XLEN | Faulting PC |
| exc_cause | input | CAUSE_W | Cause code |
| exc_has_addr | input | 1 | Request carries a faulting address |
| exc_addr | input | XLEN | Faulting virtual address |
| sr_we | input | 1 | Special-register write enable |
| sr_addr | input | 5 | Special-register address |
| sr_wdata | input | XLEN | Special-register write data |
| sr_rdata | output | XLEN | Special-register read data |
| redirect | output | 1 | One-cycle pulse: enter the handler |
| vector_id | output | 2 | Selected handler vector |

## Verification
The bench sets up each combination of EXCM and UM before a general exception. This catches a unit that selects the vector or the save register from the wrong bit, or that overwrites EPC1 during a double exception. It checks the debug gate at the edge where the current level equals the debug level and also in the case where EXCM alone raises the level. A wrong comparison would take a request that must be dropped, or would disturb state while dropping it. Collision cases pair a write with a taken request and then with a dropped one, so a unit that lets software win, or that blocks writes for any request, is reported.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  typedef struct packed {
    logic       um;
    logic       excm;
    logic [3:0] intlevel;
  } ps_t;

  localparam int PS_W = 6;

  localparam logic [4:0] SRA_PS       = 5'd0;
  localparam logic [4:0] SRA_EPC1     = 5'd1;
  localparam logic [4:0] SRA_DEPC     = 5'd2;
  localparam logic [4:0] SRA_CAUSE    = 5'd3;
  localparam logic [4:0] SRA_VADDR    = 5'd4;
  localparam logic [4:0] SRA_DBGCAUSE = 5'd5;

endpackage

// File: rtl/exc_entry_decide.sv
module exc_entry_decide
  import exc_entry_pkg::*;
#(
  parameter int EXC_LEVEL   = 3,
  parameter int DEBUG_LEVEL = 6,
  parameter int HAS_DEPC    = 1
) (
  input  ps_t  ps,
  input  logic req_valid,
  input  logic req_debug,
  output logic take_gen,
  output logic take_dbg,
  output logic save_depc,
  output logic save_epc1,
  output vec_e vec_sel
);

  logic [3:0] cur_lvl;

  always_comb begin
    cur_lvl = ps.intlevel;
    if (ps.excm && (4'(EXC_LEVEL) > ps.intlevel)) cur_lvl = 4'(EXC_LEVEL);
  end

  assign take_gen  = req_valid & ~req_debug;
  assign take_dbg  = req_valid & req_debug & (cur_lvl < 4'(DEBUG_LEVEL));
  assign save_depc = take_gen & ps.excm & (HAS_DEPC != 0);
  assign save_epc1 = take_gen & ~save_depc;

  always_comb begin
    if (req_debug)    vec_sel = VEC_DEBUG;
    else if (ps.excm) vec_sel = VEC_DOUBLE;
    else if (ps.um)   vec_sel = VEC_USER;
    else              vec_sel = VEC_KERNEL;
  end

endmodule

// File: rtl/exc_entry_level_bank.sv
module exc_entry_level_bank #(
  parameter int MAX_LEVEL   = 7,
  parameter int DEBUG_LEVEL = 6,
  parameter int XLEN        = 32,
  parameter int SAVE_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [XLEN-1:0]   cap_pc,
  input  logic [SAVE_W-1:0] cap_ps,
  input  logic              wr_epc_en,
  input  logic              wr_eps_en,
  input  logic [3:0]        wr_lvl,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [3:0]        rd_lvl,
  output logic [XLEN-1:0]   rd_epc,
  output logic [SAVE_W-1:0] rd_eps
);

  localparam int NLVL = MAX_LEVEL - 1;

  logic [XLEN-1:0]   epc_arr [NLVL];
  logic [SAVE_W-1:0] eps_arr [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam logic [3:0] LV = 4'(g + 2);
    logic [XLEN-1:0]   epc_q, epc_d;
    logic [SAVE_W-1:0] eps_q, eps_d;

    always_comb begin
      epc_d = epc_q;
      eps_d = eps_q;
      if (cap_en && (LV == 4'(DEBUG_LEVEL))) begin
        epc_d = cap_pc;
        eps_d = cap_ps;
      end else begin
        if (wr_epc_en && (wr_lvl == LV)) epc_d = wr_data;
        if (wr_eps_en && (wr_lvl == LV)) eps_d = wr_data[SAVE_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        epc_q <= '0;
        eps_q <= '0;
      end else begin
        epc_q <= epc_d;
        eps_q <= eps_d;
      end
    end

    assign epc_arr[g] = epc_q;
    assign eps_arr[g] = eps_q;
  end

  always_comb begin
    rd_epc = '0;
    rd_eps = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (rd_lvl == 4'(i + 2)) begin
        rd_epc = epc_arr[i];
        rd_eps = eps_arr[i];
      end
    end
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int MAX_LEVEL   = 7,
  parameter int DEBUG_LEVEL = 6,
  parameter int EXC_LEVEL   = 3,
  parameter int HAS_DEPC    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic               exc_debug,
  input  logic [XLEN-1:0]    exc_pc,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               exc_has_addr,
  input  logic [XLEN-1:0]    exc_addr,
  input  logic               sr_we,
  input  logic [4:0]         sr_addr,
  input  logic [XLEN-1:0]    sr_wdata,
  output logic [XLEN-1:0]    sr_rdata,
  output logic               redirect,
  output logic [1:0]         vector_id
);

  ps_t                ps_q, ps_d;
  logic [XLEN-1:0]    epc1_q, epc1_d, depc_q, vaddr_q, vaddr_d;
  logic [CAUSE_W-1:0] cause_q, cause_d, dbgc_q, dbgc_d;
  logic               redirect_q;
  vec_e               vec_q, vec_sel;
  logic               take_gen, take_dbg, save_depc, save_epc1, sr_ok;
  logic [XLEN-1:0]    bank_epc;
  logic [PS_W-1:0]    bank_eps;

  exc_entry_decide #(
    .EXC_LEVEL(EXC_LEVEL), .DEBUG_LEVEL(DEBUG_LEVEL), .HAS_DEPC(HAS_DEPC)
  ) u_decide (
    .ps(ps_q), .req_valid(exc_valid), .req_debug(exc_debug),
    .take_gen(take_gen), .take_dbg(take_dbg),
    .save_depc(save_depc), .save_epc1(save_epc1), .vec_sel(vec_sel)
  );

  assign sr_ok = sr_we & ~(take_gen | take_dbg);

  exc_entry_level_bank #(
    .MAX_LEVEL(MAX_LEVEL), .DEBUG_LEVEL(DEBUG_LEVEL), .XLEN(XLEN), .SAVE_W(PS_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cap_en(take_dbg), .cap_pc(exc_pc), .cap_ps(ps_q),
    .wr_epc_en(sr_ok && (sr_addr[4:3] == 2'b01)),
    .wr_eps_en(sr_ok && (sr_addr[4:3] == 2'b10)),
    .wr_lvl({1'b0, sr_addr[2:0]}), .wr_data(sr_wdata),
    .rd_lvl({1'b0, sr_addr[2:0]}), .rd_epc(bank_epc), .rd_eps(bank_eps)
  );

  always_comb begin
    ps_d    = ps_q;
    epc1_d  = epc1_q;
    cause_d = cause_q;
    vaddr_d = vaddr_q;
    dbgc_d  = dbgc_q;
    if (sr_ok) begin
      case (sr_addr)
        SRA_PS:       ps_d    = ps_t'(sr_wdata[PS_W-1:0]);
        SRA_EPC1:     epc1_d  = sr_wdata;
        SRA_CAUSE:    cause_d = sr_wdata[CAUSE_W-1:0];
        SRA_VADDR:    vaddr_d = sr_wdata;
        SRA_DBGCAUSE: dbgc_d  = sr_wdata[CAUSE_W-1:0];
        default: ;
      endcase
    end
    if (take_gen) begin
      cause_d  = exc_cause;
      ps_d.excm = 1'b1;
      if (save_epc1)    epc1_d  = exc_pc;
      if (exc_has_addr) vaddr_d = exc_addr;
    end
    if (take_dbg) begin
      dbgc_d        = exc_cause;
      ps_d.intlevel = 4'(DEBUG_LEVEL);
      ps_d.excm     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q       <= '0;
      epc1_q     <= '0;
      cause_q    <= '0;
      vaddr_q    <= '0;
      dbgc_q     <= '0;
      redirect_q <= 1'b0;
      vec_q      <= VEC_KERNEL;
    end else begin
      ps_q       <= ps_d;
      epc1_q     <= epc1_d;
      cause_q    <= cause_d;
      vaddr_q    <= vaddr_d;
      dbgc_q     <= dbgc_d;
      redirect_q <= take_gen | take_dbg;
      if (take_gen | take_dbg) vec_q <= vec_sel;
    end
  end

  if (HAS_DEPC != 0) begin : g_depc
    logic [XLEN-1:0] r_q, r_d;
    always_comb begin
      r_d = r_q;
      if (save_depc) r_d = exc_pc;
      else if (sr_ok && (sr_addr == SRA_DEPC)) r_d = sr_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= r_d;
    end
    assign depc_q = r_q;
  end else begin : g_no_depc
    assign depc_q = '0;
  end

  always_comb begin
    sr_rdata = '0;
    case (sr_addr)
      SRA_PS:       sr_rdata = XLEN'(ps_q);
      SRA_EPC1:     sr_rdata = epc1_q;
      SRA_DEPC:     sr_rdata = depc_q;
      SRA_CAUSE:    sr_rdata = XLEN'(cause_q);
      SRA_VADDR:    sr_rdata = vaddr_q;
      SRA_DBGCAUSE: sr_rdata = XLEN'(dbgc_q);
      default: begin
        if (sr_addr[4:3] == 2'b01)      sr_rdata = bank_epc;
        else if (sr_addr[4:3] == 2'b10) sr_rdata = XLEN'(bank_eps);
      end
    endcase
  end

  assign redirect  = redirect_q;
  assign vector_id = vec_q;

  a_r8_redirect_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !exc_debug) |=> redirect);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> !redirect);
  a_r4_excm_set: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !exc_debug) |=> ps_q.excm);
  a_r3_double_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !exc_debug && ps_q.excm) |=> (vector_id == VEC_DOUBLE));
  a_r6_gate_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_debug && (ps_q.intlevel >= 4'(DEBUG_LEVEL))) |=> !redirect);
  a_r7_level_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && (vector_id == VEC_DEBUG)) |-> (ps_q.intlevel == 4'(DEBUG_LEVEL)));
  a_r10_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && (sr_addr == SRA_CAUSE) && exc_valid && !exc_debug)
      |=> (cause_q == $past(exc_cause)));

endmodule

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;

  localparam logic [31:0] T_PC    [NT] = '{32'h1000_0010, 32'h1000_0020, 32'h1000_0030,
                                           32'h1000_0040, 32'h1000_0050, 32'h1000_0060};
  localparam logic [5:0]  T_PS    [NT] = '{6'h00, 6'h20, 6'h10, 6'h30, 6'h05, 6'h25};
  localparam logic [5:0]  T_CAUSE [NT] = '{6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd63};
  localparam logic        T_HAS   [NT] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] T_ADDR  [NT] = '{32'h0, 32'h0, 32'h2222_0000,
                                           32'h0, 32'h3333_0004, 32'h4444_0008};
  localparam logic [1:0]  T_VEC   [NT] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd0, 2'd1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0, exc_debug = 1'b0, exc_has_addr = 1'b0;
  logic [31:0] exc_pc = '0, exc_addr = '0, sr_wdata = '0;
  logic [5:0]  exc_cause = '0;
  logic        sr_we = 1'b0;
  logic [4:0]  sr_addr = '0;
  logic [31:0] sr_rdata;
  logic        redirect;
  logic [1:0]  vector_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit u0 (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_debug(exc_debug),
    .exc_pc(exc_pc), .exc_cause(exc_cause), .exc_has_addr(exc_has_addr),
    .exc_addr(exc_addr), .sr_we(sr_we), .sr_addr(sr_addr), .sr_wdata(sr_wdata),
    .sr_rdata(sr_rdata), .redirect(redirect), .vector_id(vector_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    sr_addr = a;
    #1;
    v = sr_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    sr_we = 1'b1; sr_addr = a; sr_wdata = d;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  task automatic req(input logic dbg, input logic [31:0] pc, input logic [5:0] cause,
                     input logic has, input logic [31:0] addr);
    @(negedge clk);
    exc_valid = 1'b1; exc_debug = dbg; exc_pc = pc; exc_cause = cause;
    exc_has_addr = has; exc_addr = addr;
    @(negedge clk);
    exc_valid = 1'b0; exc_debug = 1'b0; exc_has_addr = 1'b0;
    sr_we = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 redirect", {31'b0, redirect}, 32'h0);
    chk("R1 vector", {30'b0, vector_id}, 32'h0);
    for (int a = 0; a < 24; a++) begin
      rd(5'(a), v);
      chk("R1 register", v, 32'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: table of general exceptions
    for (int i = 0; i < NT; i++) begin
      wr(5'd1, 32'hAAAA_0000);
      wr(5'd2, 32'hBBBB_0000);
      wr(5'd4, 32'hCCCC_0000);
      wr(5'd0, {26'b0, T_PS[i]});
      req(1'b0, T_PC[i], T_CAUSE[i], T_HAS[i], T_ADDR[i]);
      chk("R8 redirect pulse", {31'b0, redirect}, 32'h1);
      chk("R2 R3 vector", {30'b0, vector_id}, {30'b0, T_VEC[i]});
      rd(5'd1, v); chk("R2 EPC1", v, T_PS[i][4] ? 32'hAAAA_0000 : T_PC[i]);
      rd(5'd2, v); chk("R3 DEPC", v, T_PS[i][4] ? T_PC[i] : 32'hBBBB_0000);
      rd(5'd3, v); chk("R4 EXCCAUSE", v, {26'b0, T_CAUSE[i]});
      rd(5'd0, v); chk("R4 status", v, {26'b0, T_PS[i] | 6'h10});
      rd(5'd4, v); chk("R5 EXCVADDR", v, T_HAS[i] ? T_ADDR[i] : 32'hCCCC_0000);
    end

    // R8: pulse lasts one cycle, vector held
    @(negedge clk);
    chk("R8 pulse ends", {31'b0, redirect}, 32'h0);
    chk("R8 vector held", {30'b0, vector_id}, 32'h1);

    // R7: debug entry from level 2
    wr(5'd3, 32'h0000_0011);
    wr(5'd0, 32'h02);
    req(1'b1, 32'h4000_0100, 6'd5, 1'b0, 32'h0);
    chk("R7 redirect", {31'b0, redirect}, 32'h1);
    chk("R7 vector", {30'b0, vector_id}, 32'h3);
    rd(5'd0, v);  chk("R7 status", v, 32'h16);
    rd(5'd14, v); chk("R7 level PC save", v, 32'h4000_0100);
    rd(5'd22, v); chk("R7 level status save", v, 32'h02);
    rd(5'd5, v);  chk("R7 DEBUGCAUSE", v, 32'h5);
    rd(5'd3, v);  chk("R7 EXCCAUSE kept", v, 32'h11);

    // R7: UM preserved
    wr(5'd0, 32'h25);
    req(1'b1, 32'h4000_0200, 6'd6, 1'b0, 32'h0);
    chk("R7 redirect um", {31'b0, redirect}, 32'h1);
    rd(5'd0, v);  chk("R7 status um", v, 32'h36);
    rd(5'd22, v); chk("R7 status save um", v, 32'h25);

    // R6: EXCM alone raises current level to 3, still taken
    wr(5'd0, 32'h10);
    req(1'b1, 32'h4000_0300, 6'd7, 1'b0, 32'h0);
    chk("R6 taken with excm", {31'b0, redirect}, 32'h1);
    rd(5'd14, v); chk("R6 PC save excm", v, 32'h4000_0300);

    // R6: level equal to debug level, dropped
    wr(5'd0, 32'h06);
    req(1'b1, 32'h4000_0400, 6'd9, 1'b0, 32'h0);
    chk("R6 dropped redirect", {31'b0, redirect}, 32'h0);
    rd(5'd0, v);  chk("R6 dropped status", v, 32'h06);
    rd(5'd5, v);  chk("R6 dropped DEBUGCAUSE", v, 32'h7);
    rd(5'd14, v); chk("R6 dropped PC save", v, 32'h4000_0300);

    // R6: level 7 with EXCM, dropped
    wr(5'd0, 32'h17);
    req(1'b1, 32'h4000_0500, 6'd10, 1'b0, 32'h0);
    chk("R6 dropped lvl7", {31'b0, redirect}, 32'h0);
    rd(5'd0, v); chk("R6 dropped lvl7 status", v, 32'h17);

    // R9: register map
    wr(5'd11, 32'hDEAD_0003);
    wr(5'd20, 32'hFFFF_FFFF);
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd11, v); chk("R9 level3 PC save", v, 32'hDEAD_0003);
    rd(5'd20, v); chk("R9 level4 status save", v, 32'h3F);
    rd(5'd0, v);  chk("R9 status mask", v, 32'h3F);
    rd(5'd31, v); chk("R9 unmapped", v, 32'h0);
    rd(5'd9, v);  chk("R9 level1 unmapped", v, 32'h0);

    // R10: write loses to taken exception
    wr(5'd0, 32'h00);
    @(negedge clk);
    sr_we = 1'b1; sr_addr = 5'd0; sr_wdata = 32'h20;
    exc_valid = 1'b1; exc_debug = 1'b0; exc_pc = 32'h5000_0000; exc_cause = 6'd9;
    @(negedge clk);
    exc_valid = 1'b0; sr_we = 1'b0;
    chk("R10 vector kernel", {30'b0, vector_id}, 32'h0);
    rd(5'd0, v); chk("R10 write discarded", v, 32'h10);

    // R10: write survives a dropped debug request
    wr(5'd0, 32'h07);
    @(negedge clk);
    sr_we = 1'b1; sr_addr = 5'd1; sr_wdata = 32'h0000_1234;
    exc_valid = 1'b1; exc_debug = 1'b1; exc_pc = 32'h6000_0000; exc_cause = 6'd2;
    @(negedge clk);
    exc_valid = 1'b0; exc_debug = 1'b0; sr_we = 1'b0;
    chk("R10 dropped no redirect", {31'b0, redirect}, 32'h0);
    rd(5'd1, v); chk("R10 write kept", v, 32'h0000_1234);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule